// File: doc/BRIEF.md
# Virtual Address Region Decoder and Translation Fault Recorder

This block sits beside the load/store and fetch path of a 32-bit processor. It handles one memory access per request. It takes the virtual address, the kind of access, the current privilege level and a strap that tells whether an MMU is fitted. It also takes the result of a TLB lookup that some other block performs: a hit flag, the physical page number and three permission bits.

The block sorts the address into a fixed region. Depending on the region and the privilege level, it passes the address through unchanged, translates it through the TLB result, or traps it. One cycle after a valid request it returns either a physical address or a fault with a cause code. When a translation fault occurs, it captures the state that a software refill handler needs into three registers:
- the faulting address;
- a page-table-entry pointer, which keeps a software-set base and takes the faulting page number;
- a flag telling whether the fault came from a data access or an instruction fetch.

Top module: `mmu_region_xlate`

## Requirements
- R1: After synchronous reset, rsp_valid and rsp_fault are low, and bad_addr, pte_addr and tlbmisc_data are all zero.
- R2: rsp_valid is high exactly in the cycle after a cycle in which req_valid was high. The result describes that request.
- R3: With mmu_present low, every access completes without fault and rsp_paddr equals req_vaddr.
- R4: With MMU present and req_super high, an address at or above 0xC0000000 completes without fault, rsp_paddr equals req_vaddr, and the TLB inputs are ignored.
- R5: With MMU present and req_super low, an address at or above 0x80000000 faults with cause 5, bad_addr takes the address, and pte_addr and tlbmisc_data keep their values.
- R6: Other addresses are translated. The access type is encoded as 0 = read, 1 = write, and 2 or 3 = fetch. When tlb_hit is high and the matching permission is set (tlb_rd_ok, tlb_wr_ok or tlb_ex_ok), there is no fault and rsp_paddr = {tlb_ppn, req_vaddr[11:0]}.
- R7: A translated access that hits without the matching permission faults with cause 2 (read), 3 (write) or 4 (fetch).
- R8: A translated access that misses faults with cause 1, whatever the permission inputs are.
- R9: On a cause 1 to 4 fault, tlbmisc_data becomes 0 for a fetch and 1 for a read or write.
- R10: On a cause 1 to 4 fault, bad_addr takes the address and pte_addr becomes {old pte_addr[31:22], req_vaddr[31:12], 2'b00}.
- R11: A response without fault, or a cycle with no response, leaves bad_addr and tlbmisc_data unchanged. rsp_paddr reads zero whenever rsp_fault is high.
- R12: A cycle with cfg_ptb_we high loads cfg_ptb into pte_addr[31:22] and leaves pte_addr[21:0] unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ptb_we | input | 1 | Write strobe for the page-table base field |
| cfg_ptb | input | 10 | New page-table base value |
| mmu_present | input | 1 | Strap: an MMU is fitted |
| req_valid | input | 1 | An access request is present |
| req_vaddr | input | 32 | Virtual address of the access |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2/3 fetch |
| req_super | input | 1 | Access is made in supervisor mode |
| tlb_hit | input | 1 | The TLB lookup found an entry |
| tlb_ppn | input | 20 | Physical page number of the entry |
| tlb_rd_ok | input | 1 | The entry allows reads |
| tlb_wr_ok | input | 1 | The entry allows writes |
| tlb_ex_ok | input | 1 | The entry allows fetches |
| rsp_valid | output | 1 | A result is present |
| rsp_fault | output | 1 | The access faulted |
| rsp_cause | output | 3 | Fault cause: 0 none, 1 miss, 2/3/4 read/write/fetch permission, 5 user access to kernel space |
| rsp_paddr | output | 32 | Physical address; zero on fault |
| bad_addr | output | 32 | Last faulting virtual address |
| pte_addr | output | 32 | Page-table base [31:22] and faulting page number [21:2] |
| tlbmisc_data | output | 1 | Last translation fault was a data access |

## Verification
The bench builds the block with its default 32-bit address and 4 KB page, because the region boundaries are tied to the top address bits. It sweeps every combination of the MMU strap, the privilege level, the four access codes, hit versus miss and all eight permission patterns. Each combination runs against eight addresses placed on both sides of the 0x80000000 and 0xC0000000 boundaries and at the page-offset extremes. This covers every region and fault path, including faults that arrive one after another and accumulate in the captured registers. The page-table base is rewritten part-way through, so the bench can check that the base field survives later faults.

// File: rtl/mmu_rd_pkg.sv
package mmu_rd_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_MISS   = 3'd1,
    CAUSE_PERM_R = 3'd2,
    CAUSE_PERM_W = 3'd3,
    CAUSE_PERM_X = 3'd4,
    CAUSE_SUPER  = 3'd5
  } fault_cause_e;

  typedef enum logic [1:0] {
    RGN_IDENT,
    RGN_XLATE,
    RGN_TRAP
  } region_e;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;

endpackage

// File: rtl/mmu_region_class.sv
module mmu_region_class
  import mmu_rd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic              super_mode,
  input  logic              mmu_present,
  output region_e           region
);

  logic in_kernel;
  logic in_bypass;

  assign in_kernel = vaddr[ADDR_W-1];
  assign in_bypass = &vaddr[ADDR_W-1 -: 2];

  always_comb begin
    if (!mmu_present) begin
      region = RGN_IDENT;
    end else if (super_mode) begin
      region = in_bypass ? RGN_IDENT : RGN_XLATE;
    end else begin
      region = in_kernel ? RGN_TRAP : RGN_XLATE;
    end
  end

endmodule

// File: rtl/mmu_page_check.sv
module mmu_page_check
  import mmu_rd_pkg::*;
#(
  parameter  int ADDR_W = 32,
  parameter  int PAGE_W = 12,
  localparam int VPN_W  = ADDR_W - PAGE_W
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [1:0]        acc,
  input  logic              hit,
  input  logic [VPN_W-1:0]  ppn,
  input  logic              rd_ok,
  input  logic              wr_ok,
  input  logic              ex_ok,
  output logic              fault,
  output fault_cause_e      cause,
  output logic [ADDR_W-1:0] paddr
);

  logic allowed;

  always_comb begin
    unique case (acc)
      ACC_READ:  allowed = rd_ok;
      ACC_WRITE: allowed = wr_ok;
      default:   allowed = ex_ok;
    endcase
  end

  always_comb begin
    paddr = '0;
    fault = 1'b1;
    if (!hit) begin
      cause = CAUSE_MISS;
    end else if (!allowed) begin
      unique case (acc)
        ACC_READ:  cause = CAUSE_PERM_R;
        ACC_WRITE: cause = CAUSE_PERM_W;
        default:   cause = CAUSE_PERM_X;
      endcase
    end else begin
      cause = CAUSE_NONE;
      fault = 1'b0;
      paddr = {ppn, vaddr[PAGE_W-1:0]};
    end
  end

endmodule

// File: rtl/mmu_fault_regs.sv
module mmu_fault_regs #(
  parameter  int ADDR_W = 32,
  parameter  int PAGE_W = 12,
  localparam int VPN_W  = ADDR_W - PAGE_W,
  localparam int PTB_W  = PAGE_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_addr,
  input  logic              cap_xlate,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic              is_fetch,
  input  logic              base_we,
  input  logic [PTB_W-1:0]  base_val,
  output logic [ADDR_W-1:0] bad_addr,
  output logic [ADDR_W-1:0] pte_addr,
  output logic              data_flag
);

  logic [PTB_W-1:0] base_q;
  logic [VPN_W-1:0] vpn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bad_addr  <= '0;
      base_q    <= '0;
      vpn_q     <= '0;
      data_flag <= 1'b0;
    end else begin
      if (cap_addr) bad_addr <= vaddr;
      if (base_we)  base_q   <= base_val;
      if (cap_xlate) begin
        vpn_q     <= vaddr[ADDR_W-1:PAGE_W];
        data_flag <= !is_fetch;
      end
    end
  end

  assign pte_addr = {base_q, vpn_q, 2'b00};

endmodule

// File: rtl/mmu_region_xlate.sv
module mmu_region_xlate
  import mmu_rd_pkg::*;
#(
  parameter  int ADDR_W = 32,
  parameter  int PAGE_W = 12,
  localparam int VPN_W  = ADDR_W - PAGE_W,
  localparam int PTB_W  = PAGE_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_ptb_we,
  input  logic [PTB_W-1:0]  cfg_ptb,
  input  logic              mmu_present,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [1:0]        req_acc,
  input  logic              req_super,
  input  logic              tlb_hit,
  input  logic [VPN_W-1:0]  tlb_ppn,
  input  logic              tlb_rd_ok,
  input  logic              tlb_wr_ok,
  input  logic              tlb_ex_ok,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [2:0]        rsp_cause,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [ADDR_W-1:0] bad_addr,
  output logic [ADDR_W-1:0] pte_addr,
  output logic              tlbmisc_data
);

  region_e           region;
  logic              pc_fault;
  fault_cause_e      pc_cause;
  logic [ADDR_W-1:0] pc_paddr;

  logic              nx_fault;
  fault_cause_e      nx_cause;
  logic [ADDR_W-1:0] nx_paddr;
  logic              cap_xlate;
  logic              cap_addr;

  mmu_region_class #(.ADDR_W(ADDR_W)) u_class (
    .vaddr       (req_vaddr),
    .super_mode  (req_super),
    .mmu_present (mmu_present),
    .region      (region)
  );

  mmu_page_check #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_check (
    .vaddr (req_vaddr),
    .acc   (req_acc),
    .hit   (tlb_hit),
    .ppn   (tlb_ppn),
    .rd_ok (tlb_rd_ok),
    .wr_ok (tlb_wr_ok),
    .ex_ok (tlb_ex_ok),
    .fault (pc_fault),
    .cause (pc_cause),
    .paddr (pc_paddr)
  );

  always_comb begin
    unique case (region)
      RGN_IDENT: begin
        nx_fault = 1'b0;
        nx_cause = CAUSE_NONE;
        nx_paddr = req_vaddr;
      end
      RGN_TRAP: begin
        nx_fault = 1'b1;
        nx_cause = CAUSE_SUPER;
        nx_paddr = '0;
      end
      default: begin
        nx_fault = pc_fault;
        nx_cause = pc_cause;
        nx_paddr = pc_paddr;
      end
    endcase
  end

  assign cap_xlate = req_valid && (region == RGN_XLATE) && pc_fault;
  assign cap_addr  = req_valid && nx_fault;

  mmu_fault_regs #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cap_addr  (cap_addr),
    .cap_xlate (cap_xlate),
    .vaddr     (req_vaddr),
    .is_fetch  (req_acc[1]),
    .base_we   (cfg_ptb_we),
    .base_val  (cfg_ptb),
    .bad_addr  (bad_addr),
    .pte_addr  (pte_addr),
    .data_flag (tlbmisc_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= CAUSE_NONE;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid && nx_fault;
      rsp_cause <= req_valid ? nx_cause : CAUSE_NONE;
      rsp_paddr <= req_valid ? nx_paddr : '0;
    end
  end

endmodule

// File: rtl/mmu_region_xlate_chk.sv
module mmu_region_xlate_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              mmu_present,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic              req_super,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic [2:0]        rsp_cause,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic [ADDR_W-1:0] bad_addr,
  input logic              tlbmisc_data
);

  p_resp_follows_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  p_identity_nommu_r3: assert property (@(posedge clk) disable iff (rst)
    req_valid && !mmu_present |=> !rsp_fault && rsp_paddr == $past(req_vaddr));

  p_user_trap_r5: assert property (@(posedge clk) disable iff (rst)
    req_valid && mmu_present && !req_super && req_vaddr[ADDR_W-1]
      |=> rsp_fault && rsp_cause == 3'd5);

  p_badaddr_capture_r10: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_fault -> bad_addr == $past(req_vaddr)));

  p_hold_on_ok_r11: assert property (@(posedge clk) disable iff (rst)
    !rsp_fault |-> $stable(bad_addr) && $stable(tlbmisc_data));

  p_paddr_zero_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> rsp_valid && rsp_paddr == '0);

endmodule

bind mmu_region_xlate mmu_region_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .mmu_present  (mmu_present),
  .req_valid    (req_valid),
  .req_vaddr    (req_vaddr),
  .req_super    (req_super),
  .rsp_valid    (rsp_valid),
  .rsp_fault    (rsp_fault),
  .rsp_cause    (rsp_cause),
  .rsp_paddr    (rsp_paddr),
  .bad_addr     (bad_addr),
  .tlbmisc_data (tlbmisc_data)
);

// File: tb/tb_mmu_region_xlate.sv
module tb_mmu_region_xlate;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_ptb_we;
  logic [9:0]  cfg_ptb;
  logic        mmu_present;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic [1:0]  req_acc;
  logic        req_super;
  logic        tlb_hit;
  logic [19:0] tlb_ppn;
  logic        tlb_rd_ok, tlb_wr_ok, tlb_ex_ok;
  logic        rsp_valid, rsp_fault;
  logic [2:0]  rsp_cause;
  logic [31:0] rsp_paddr, bad_addr, pte_addr;
  logic        tlbmisc_data;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic [31:0] m_bad, m_pte;
  logic        m_d;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmu_region_xlate dut (
    .clk(clk), .rst(rst), .cfg_ptb_we(cfg_ptb_we), .cfg_ptb(cfg_ptb),
    .mmu_present(mmu_present), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_acc(req_acc), .req_super(req_super), .tlb_hit(tlb_hit),
    .tlb_ppn(tlb_ppn), .tlb_rd_ok(tlb_rd_ok), .tlb_wr_ok(tlb_wr_ok),
    .tlb_ex_ok(tlb_ex_ok), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr), .bad_addr(bad_addr),
    .pte_addr(pte_addr), .tlbmisc_data(tlbmisc_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] addr_of(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h1234_5ABC;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'hBFFF_F001;
      5: return 32'hC000_0000;
      6: return 32'hDEAD_BEEF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic run_one(input bit mp, input bit su, input int ai, input int ty,
                         input bit hit, input int pm);
    logic [31:0] a;
    logic [19:0] ppn;
    bit ok, xf, sf;
    logic [2:0] cause;
    logic [31:0] pa;
    string rt;
    a   = addr_of(ai);
    ppn = 20'hA5000 ^ 20'(ai * 37 + pm * 5 + ty * 311);
    @(negedge clk);
    mmu_present = mp; req_super = su; req_vaddr = a; req_acc = 2'(ty);
    tlb_hit = hit; tlb_ppn = ppn;
    tlb_rd_ok = pm[0]; tlb_wr_ok = pm[1]; tlb_ex_ok = pm[2];
    req_valid = 1'b1;
    xf = 0; sf = 0; cause = 3'd0; pa = a;
    if (!mp) rt = "R3";
    else if (su && a[31:30] == 2'b11) rt = "R4";
    else if (!su && a[31]) begin rt = "R5"; sf = 1; cause = 3'd5; pa = 32'h0; end
    else begin
      ok = (ty == 0) ? pm[0] : (ty == 1) ? pm[1] : pm[2];
      if (!hit) begin rt = "R8"; xf = 1; cause = 3'd1; end
      else if (!ok) begin rt = "R7"; xf = 1; cause = (ty == 0) ? 3'd2 : (ty == 1) ? 3'd3 : 3'd4; end
      else begin rt = "R6"; pa = {ppn, a[11:0]}; end
      if (xf) pa = 32'h0;
    end
    if (xf || sf) m_bad = a;
    if (xf) begin
      m_pte = {m_pte[31:22], a[31:12], 2'b00};
      m_d   = (ty < 2);
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 rsp_valid", 32'(rsp_valid), 32'd1);
    chk({rt, " fault"}, 32'(rsp_fault), 32'(xf | sf));
    chk({rt, " cause"}, 32'(rsp_cause), 32'(cause));
    chk({rt, (xf | sf) ? " R11 paddr" : " paddr"}, rsp_paddr, pa);
    chk(xf ? "R10 bad_addr" : sf ? "R5 bad_addr" : "R11 bad_addr", bad_addr, m_bad);
    chk(xf ? "R10 pte_addr" : "R5/R11 pte_addr", pte_addr, m_pte);
    chk(xf ? "R9 data flag" : "R11 data flag", 32'(tlbmisc_data), 32'(m_d));
    @(negedge clk);
    chk("R2 idle", 32'(rsp_valid), 32'd0);
  endtask

  task automatic write_base(input logic [9:0] b);
    @(negedge clk);
    cfg_ptb_we = 1'b1; cfg_ptb = b;
    m_pte = {b, m_pte[21:0]};
    @(negedge clk);
    cfg_ptb_we = 1'b0;
    chk("R12 pte base", pte_addr, m_pte);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_ptb_we = 1'b0; cfg_ptb = '0; mmu_present = 1'b0;
    req_valid = 1'b0; req_vaddr = '0; req_acc = '0; req_super = 1'b0;
    tlb_hit = 1'b0; tlb_ppn = '0; tlb_rd_ok = 1'b0; tlb_wr_ok = 1'b0; tlb_ex_ok = 1'b0;
    m_bad = '0; m_pte = '0; m_d = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 rsp_fault", 32'(rsp_fault), 32'd0);
    chk("R1 bad_addr", bad_addr, 32'd0);
    chk("R1 pte_addr", pte_addr, 32'd0);
    chk("R1 data flag", 32'(tlbmisc_data), 32'd0);
    write_base(10'h2A5);
    for (int mp = 0; mp < 2; mp++) begin
      if (mp == 1) write_base(10'h15B);
      for (int su = 0; su < 2; su++)
        for (int ai = 0; ai < 8; ai++)
          for (int ty = 0; ty < 4; ty++)
            for (int h = 0; h < 2; h++)
              for (int pm = 0; pm < 8; pm++)
                run_one(mp[0], su[0], ai, ty, h[0], pm);
    end
    write_base(10'h3FF);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule